// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is an up-counting timer controlled through a small register port. A programmable prescaler divides a selected clock source, either the system clock or the system clock divided by sixteen. Each prescaler output tick advances a 16-bit counter. When the counter equals a programmed reference value and restart-on-reference is enabled, the next tick returns the counter to zero and raises a reference-event flag. The interrupt line follows that flag, gated by an enable bit.

Software sets the reference first. It then writes the control register with the run bit set, which starts the timer. It clears the event flag by writing a one to it. Any write to the control register or the reference register restarts counting from zero with the new settings. If a control write takes the run bit from 1 to 0, every register returns to its reset value.

Top module: `refcmp_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the reference reads 0xFFFF, the counter reads 0, the event register reads 0 and `irq` is low.
- R2: While control bit 0 (run) is 0, the counter stays at 0. A control write that leaves run at 0 stores its value unchanged.
- R3: Control bits [2:1] select the tick source. Value 1 gives one prescaler input per clock, value 2 gives one per 16 clocks, and values 0 and 3 stop the counter.
- R4: The prescaler divides its input by control bits [15:8] plus one, so the divisor ranges from 1 to 256.
- R5: If control bit 3 (restart-on-reference) is 1, a tick that finds the counter equal to the reference loads 0 into the counter and sets event bit 1.
- R6: If control bit 3 is 0, the counter passes the reference and keeps counting, and event bit 1 is not set.
- R7: `irq` is high exactly when control bit 4 (interrupt enable) and event bit 1 are both 1.
- R8: The event register at offset 0x11 is write-one-to-clear. Writing 1 to bit 1 clears the flag, and writing 0 to a bit leaves it unchanged. If a new event arrives in the same cycle as the clear, the event is kept.
- R9: A write to the control register (0x00) or the reference register (0x04) restarts the count at 0 and clears the prescaler.
- R10: A write to the counter register (0x0C) while running loads that value, and counting continues from it.
- R11: A control write that changes bit 0 from 1 to 0 returns the control, reference, counter and event registers to their reset values.
- R12: The capture offset 0x08 and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | Write when 1, read when 0 |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `sel` is high |
| irq | output | 1 | Reference interrupt request |

## Verification
The counter is read in consecutive cycles under four source settings: every clock, divide-by-three prescaling, the divide-by-sixteen source, and a stopped source. This separates the off-by-one errors in the divisor from errors in the sixteen-clock phase. Runs with restart-on-reference set and cleared show whether the wrap and the flag depend on that bit. Event writes with the wrong bit and with the right bit test the write-one-to-clear rule. Gating the interrupt enable on and off with the flag held shows that `irq` follows both bits. A final control write that drops the run bit checks that the soft reset restores the defaults.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SYS16 = 2'd2,
    SRC_OFF3  = 2'd3
  } clk_src_e;

  localparam logic [4:0] A_MODE = 5'h00;
  localparam logic [4:0] A_REF  = 5'h04;
  localparam logic [4:0] A_CAP  = 5'h08;
  localparam logic [4:0] A_CNT  = 5'h0C;
  localparam logic [4:0] A_EVT  = 5'h11;

  localparam int MB_RUN     = 0;
  localparam int MB_SRC_LSB = 1;
  localparam int MB_RESTART = 3;
  localparam int MB_IRQEN   = 4;
  localparam int MB_PS_LSB  = 8;
  localparam int EB_REF     = 1;

  // one prescaler input arrives this cycle
  function automatic logic src_fires(input logic [1:0] src, input logic phase_last);
    return (src == SRC_SYS) || ((src == SRC_SYS16) && phase_last);
  endfunction

endpackage

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler
  import refcmp_pkg::*;
#(
  parameter int PS_W = 8,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [1:0]      src,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);

  logic [PH_W-1:0] phase;
  logic [PS_W-1:0] pcnt;
  logic            src_en;

  assign src_en = run && src_fires(src, phase == {PH_W{1'b1}});
  assign tick   = src_en && (pcnt == ps);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr) begin
      phase <= '0;
      pcnt  <= '0;
    end else begin
      if (src == SRC_SYS16) phase <= phase + 1'b1;
      if (src_en) pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end

  p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && src == SRC_SYS16) |=> phase == $past(phase) + 1'b1);

  p_src_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_OFF || src == SRC_OFF3) |-> !tick);

  p_pre_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && src_en && !tick) |=> pcnt == $past(pcnt) + 1'b1);

endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic         tick,
  input  logic         restart_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] ref_val,
  output logic [W-1:0] cnt,
  output logic         ref_hit
);

  function automatic logic [W-1:0] f_next(input logic [W-1:0] c, input logic hit);
    return hit ? '0 : c + 1'b1;
  endfunction

  assign ref_hit = run && tick && restart_en && (cnt == ref_val);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || clr) cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick)             cnt <= f_next(cnt, ref_hit);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !clr && !load) |=> cnt == '0);

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !restart_en && !clr && !load) |=> cnt == $past(cnt) + 1'b1);

  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && load) |=> cnt == $past(load_val));

endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [4:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int PS_W  = DATA_W - MB_PS_LSB;
  localparam int EVT_W = 8;

  logic [DATA_W-1:0] mode_q, ref_q, cnt;
  logic [EVT_W-1:0]  evt_q;
  logic wr_mode, wr_ref, wr_cnt, wr_evt, soft_rst, restart, tick, ref_hit;

  assign wr_mode  = sel && wr && (addr == A_MODE);
  assign wr_ref   = sel && wr && (addr == A_REF);
  assign wr_cnt   = sel && wr && (addr == A_CNT);
  assign wr_evt   = sel && wr && (addr == A_EVT);
  assign soft_rst = wr_mode && mode_q[MB_RUN] && !wdata[MB_RUN];
  assign restart  = wr_mode || wr_ref;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      mode_q <= '0;
      ref_q  <= '1;
      evt_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ref)  ref_q  <= wdata;
      evt_q <= (evt_q & ~(wr_evt ? wdata[EVT_W-1:0] : '0))
             | (EVT_W'(ref_hit) << EB_REF);
    end
  end

  refcmp_prescaler #(.PS_W(PS_W), .PH_W(PH_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode_q[MB_RUN]),
    .clr   (restart),
    .src   (mode_q[MB_SRC_LSB +: 2]),
    .ps    (mode_q[MB_PS_LSB +: PS_W]),
    .tick  (tick)
  );

  refcmp_counter #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (mode_q[MB_RUN]),
    .clr        (restart),
    .tick       (tick),
    .restart_en (mode_q[MB_RESTART]),
    .load       (wr_cnt),
    .load_val   (wdata),
    .ref_val    (ref_q),
    .cnt        (cnt),
    .ref_hit    (ref_hit)
  );

  assign irq = mode_q[MB_IRQEN] && evt_q[EB_REF];

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (addr)
        A_MODE:  rdata = mode_q;
        A_REF:   rdata = ref_q;
        A_CNT:   rdata = cnt;
        A_EVT:   rdata = DATA_W'(evt_q);
        default: rdata = '0;
      endcase
    end
  end

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && mode_q[MB_IRQEN] && !wr_mode) |=> irq);

  p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wdata[EB_REF] && !ref_hit) |=> !evt_q[EB_REF]);

  p_evt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[EB_REF] && !wr_evt && !soft_rst) |=> evt_q[EB_REF]);

  p_soft_rst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_q == '0 && ref_q == '1 && evt_q == '0));

endmodule

// File: tb/refcmp_timer_tb.sv
`timescale 1ns/1ps
module refcmp_timer_tb;
  import refcmp_pkg::*;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic        mon_go = 1'b0;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;
  item_t       sb[$];

  always #10 clk = ~clk;

  refcmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pops one expected item per read and compares mid-cycle
  initial forever begin
    @(negedge clk);
    if (mon_go && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    sel = 1'b1; wr = 1'b0; addr = a; mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0; sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset values
    rd(A_MODE, 16'h0000, "R1 mode");
    rd(A_REF,  16'hFFFF, "R1 ref");
    rd(A_CNT,  16'h0000, "R1 cnt");
    rd(A_EVT,  16'h0000, "R1 evt");
    chk_irq(1'b0, "R1 irq");

    // R2 held while run bit is 0
    wr_reg(A_REF, 16'd5);
    wr_reg(A_MODE, 16'h001A);
    step(5);
    rd(A_CNT,  16'h0000, "R2 held");
    rd(A_MODE, 16'h001A, "R2 stored");

    // R3 / R5 every clock, ref 5
    wr_reg(A_MODE, 16'h001B);
    for (int i = 0; i < 6; i++) rd(A_CNT, 16'(i), "R3 count");
    rd(A_CNT, 16'h0000, "R5 wrap");
    rd(A_EVT, 16'h0002, "R5 flag");
    chk_irq(1'b1, "R7 irq set");

    // R3 stopped sources
    wr_reg(A_MODE, 16'h0019);
    step(4);
    rd(A_CNT, 16'h0000, "R3 src0 stop");
    wr_reg(A_MODE, 16'h001F);
    step(4);
    rd(A_CNT, 16'h0000, "R3 src3 stop");

    // R7 enable gating
    wr_reg(A_MODE, 16'h0009);
    chk_irq(1'b0, "R7 irq disabled");
    rd(A_EVT, 16'h0002, "R7 flag kept");
    wr_reg(A_MODE, 16'h0019);
    chk_irq(1'b1, "R7 irq enabled");

    // R8 write-one-to-clear
    wr_reg(A_EVT, 16'h0001);
    rd(A_EVT, 16'h0002, "R8 other bit ignored");
    wr_reg(A_EVT, 16'h0002);
    rd(A_EVT, 16'h0000, "R8 cleared");
    chk_irq(1'b0, "R8 irq dropped");

    // R4 divisor 3
    wr_reg(A_REF, 16'd100);
    wr_reg(A_MODE, 16'h021B);
    for (int i = 0; i < 7; i++) rd(A_CNT, 16'(i / 3), "R4 prescale");

    // R3 divide-by-16 source
    wr_reg(A_MODE, 16'h000D);
    step(15);
    rd(A_CNT, 16'd0, "R3 div16 before");
    rd(A_CNT, 16'd1, "R3 div16 first");
    step(14);
    rd(A_CNT, 16'd1, "R3 div16 hold");
    rd(A_CNT, 16'd2, "R3 div16 second");

    // R10 counter load
    wr_reg(A_MODE, 16'h0009);
    wr_reg(A_CNT, 16'h1234);
    rd(A_CNT, 16'h1234, "R10 load stopped");
    wr_reg(A_MODE, 16'h0003);
    wr_reg(A_CNT, 16'h00F0);
    rd(A_CNT, 16'h00F0, "R10 load running");
    rd(A_CNT, 16'h00F1, "R10 continue");

    // R6 no restart: passes reference
    wr_reg(A_REF, 16'd3);
    wr_reg(A_MODE, 16'h0013);
    for (int i = 0; i < 6; i++) rd(A_CNT, 16'(i), "R6 pass ref");
    rd(A_EVT, 16'h0000, "R6 no flag");
    chk_irq(1'b0, "R6 irq low");

    // R9 reference write restarts
    wr_reg(A_REF, 16'd50);
    wr_reg(A_MODE, 16'h001B);
    step(10);
    wr_reg(A_REF, 16'd60);
    rd(A_CNT, 16'd0, "R9 restart");
    rd(A_CNT, 16'd1, "R9 resume");

    // R12 capture and unmapped
    rd(A_CAP, 16'h0000, "R12 capture");
    rd(5'h02, 16'h0000, "R12 unmapped");

    // R11 soft reset
    wr_reg(A_REF, 16'd2);
    step(5);
    rd(A_EVT, 16'h0002, "R5 flag again");
    wr_reg(A_MODE, 16'hFF10);
    rd(A_MODE, 16'h0000, "R11 mode");
    rd(A_REF,  16'hFFFF, "R11 ref");
    rd(A_EVT,  16'h0000, "R11 evt");
    rd(A_CNT,  16'h0000, "R11 cnt");
    chk_irq(1'b0, "R11 irq");

    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule